// File: doc/BRIEF.md
# Eight-Pulse Burst Generator

This block turns one pulse on a single input line into a burst of output pulses on a single output line. The input must first be seen high, which arms the controller. The burst starts when the input is next seen low. The number of pulses in a burst is two to the power of the counter width, which is eight with the default width of three bits.

The controller is a four-state machine. Each state has its own flip-flop: armed, pulsing, spacing and idle. A wrap-around counter records how many pulses have gone out, and the burst ends when the counter returns to zero. A power-on reset puts the machine in the idle state and clears the counter.

Everything runs on one clock. The input is expected to be synchronous already. It is ignored while a burst is in progress. The one-hot state vector, the counter and the counter's zero flag are brought out so that the sequence can be observed.

Top module: `burst_pulse_gen`

## Requirements
- R1: While `rst_por` is high, and on the first cycle after it is released, `state_o` equals 4'b1000 (idle), `pulse_cnt_o` is 0, `cnt_zero_o` is 1 and `pulse_out` is 0.
- R2: `state_o` always has exactly one bit set. The bits are: bit 0 armed, bit 1 pulsing, bit 2 spacing, bit 3 idle.
- R3: In idle, a high `trig_in` at a clock edge moves the machine to armed. A low `trig_in` keeps it in idle.
- R4: The machine stays in armed for as long as `trig_in` is high, and `pulse_out` stays 0 during that time. The first clock edge that samples `trig_in` low moves the machine to pulsing.
- R5: Pulsing always moves to spacing at the next edge, and each such edge adds one to the counter, modulo 2**CNT_W. The counter holds its value in every other state.
- R6: In spacing, the machine returns to pulsing if the counter is nonzero and goes to idle if it is zero.
- R7: `pulse_out` is high exactly while the machine is in pulsing. One input pulse produces exactly 2**CNT_W output pulses (8 by default). Each output pulse is one clock wide and starts two clocks after the previous one. The first output pulse is high in the cycle that follows the edge at which the low input was sampled.
- R8: `trig_in` has no effect while the machine is in pulsing or spacing. A new burst can be armed only after the machine is back in idle.
- R9: `cnt_zero_o` is high exactly when all counter bits are zero. The counter reads zero whenever the machine is in idle or armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Asynchronous power-on reset, active high |
| trig_in | input | 1 | Trigger line: arms on high, fires on low |
| pulse_out | output | 1 | Burst output, high while in pulsing |
| state_o | output | 4 | One-hot state {idle, spacing, pulsing, armed} |
| pulse_cnt_o | output | CNT_W | Pulses issued in the current burst, modulo 2**CNT_W |
| cnt_zero_o | output | 1 | High when the counter is zero |

## Verification
On every cycle, the assertions check the following:
- The state vector stays one-hot.
- Each state moves to the state it must reach next.
- The counter steps by exactly one after a pulsing cycle and holds otherwise.
- Idle always sees a zero counter.
- No output pulse is wider than one clock.

Some behaviour only the bench's scenarios can show:
- Exactly eight pulses arrive in each burst, at the exact cycles expected.
- The first pulse follows the falling input by one edge, whatever the width of the input pulse.
- The input is truly ignored when it is toggled in the middle of a burst.

// File: rtl/burst_pulse_gen.sv
module burst_pulse_gen #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_por,
  input  logic             trig_in,
  output logic             pulse_out,
  output logic [3:0]       state_o,
  output logic [CNT_W-1:0] pulse_cnt_o,
  output logic             cnt_zero_o
);

  logic armed_q, pulsing_q, spacing_q, idle_q;
  logic [CNT_W-1:0] cnt_q;
  logic cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk or posedge rst_por) begin
    if (rst_por) begin
      armed_q   <= 1'b0;
      pulsing_q <= 1'b0;
      spacing_q <= 1'b0;
      idle_q    <= 1'b1;
    end else begin
      armed_q   <= (idle_q | armed_q) & trig_in;
      pulsing_q <= (armed_q & ~trig_in) | (spacing_q & ~cnt_zero);
      spacing_q <= pulsing_q;
      idle_q    <= (spacing_q & cnt_zero) | (idle_q & ~trig_in);
    end
  end

  always_ff @(posedge clk or posedge rst_por) begin
    if (rst_por)        cnt_q <= '0;
    else if (pulsing_q) cnt_q <= cnt_q + 1'b1;
  end

  assign pulse_out   = pulsing_q;
  assign state_o     = {idle_q, spacing_q, pulsing_q, armed_q};
  assign pulse_cnt_o = cnt_q;
  assign cnt_zero_o  = cnt_zero;

  AST_ONE_HOT: assert property (@(posedge clk) disable iff (rst_por) $countones(state_o) == 1); // R2
  AST_IDLE_ARM: assert property (@(posedge clk) disable iff (rst_por) idle_q && trig_in |=> armed_q); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst_por) idle_q && !trig_in |=> idle_q); // R3
  AST_ARM_FIRE: assert property (@(posedge clk) disable iff (rst_por) armed_q && !trig_in |=> pulsing_q); // R4
  AST_PULSE_SPACE: assert property (@(posedge clk) disable iff (rst_por) pulsing_q |=> spacing_q); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst_por) pulsing_q |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R5
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst_por) !pulsing_q |=> $stable(cnt_q)); // R5
  AST_SPACE_LOOP: assert property (@(posedge clk) disable iff (rst_por) spacing_q && !cnt_zero |=> pulsing_q); // R6
  AST_SPACE_END: assert property (@(posedge clk) disable iff (rst_por) spacing_q && cnt_zero |=> idle_q); // R6
  AST_PULSE_NARROW: assert property (@(posedge clk) disable iff (rst_por) pulse_out |=> !pulse_out); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst_por) (idle_q || armed_q) |-> cnt_zero_o); // R9

endmodule

// File: tb/burst_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module burst_pulse_gen_tb_top;
  localparam int CNT_W = 3;
  localparam int BURST = 1 << CNT_W;

  logic clk = 1'b0;
  logic rst_por = 1'b1;
  logic trig_in = 1'b0;
  logic pulse_out, cnt_zero_o;
  logic [3:0] state_o;
  logic [CNT_W-1:0] pulse_cnt_o;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  int exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  burst_pulse_gen #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_por(rst_por), .trig_in(trig_in), .pulse_out(pulse_out),
    .state_o(state_o), .pulse_cnt_o(pulse_cnt_o), .cnt_zero_o(cnt_zero_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // monitor: every output pulse must match the next expected cycle (R7)
  always @(negedge clk) begin
    if (!rst_por && pulse_out) begin
      if (exp_q.size() == 0) chk(1'b0, "R7", "unexpected pulse", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(e == cyc, "R7", "pulse cycle", cyc, e);
      end
    end
  end

  task automatic burst(input int width, input bit toggle);
    int n;
    @(negedge clk);
    trig_in = 1'b1;
    @(negedge clk);
    chk(state_o == 4'b0001, "R3", "armed after high", state_o, 4'b0001);
    for (int i = 1; i < width; i++) @(negedge clk);
    chk(state_o == 4'b0001, "R4", "armed while high", state_o, 4'b0001);
    chk(pulse_out == 1'b0, "R4", "no output while armed", pulse_out, 0);
    trig_in = 1'b0;
    n = cyc;
    for (int k = 0; k < BURST; k++) exp_q.push_back(n + 1 + 2 * k);
    for (int d = 1; d <= 2 * BURST + 1; d++) begin
      @(negedge clk);
      if (d == 1) chk(state_o == 4'b0010, "R4", "pulsing after fall", state_o, 4'b0010);
      if (d == 2) begin
        chk(state_o == 4'b0100, "R5", "spacing after pulse", state_o, 4'b0100);
        chk(pulse_cnt_o == 1, "R5", "count after first pulse", pulse_cnt_o, 1);
        chk(cnt_zero_o == 1'b0, "R9", "zero flag low", cnt_zero_o, 0);
      end
      if (toggle) begin
        if (d == 3 || d == 11) trig_in = 1'b1;
        if (d == 8 || d == 14) trig_in = 1'b0;
      end
      if (d == 2 * BURST) begin
        chk(state_o == 4'b0100, "R6", "last spacing", state_o, 4'b0100);
        chk(pulse_cnt_o == 0, "R6", "wrapped count", pulse_cnt_o, 0);
      end
      if (d == 2 * BURST + 1) begin
        chk(state_o == 4'b1000, "R6", "idle after burst", state_o, 4'b1000);
        chk(pulse_cnt_o == 0 && cnt_zero_o, "R9", "zero in idle", pulse_cnt_o, 0);
        chk(exp_q.size() == 0, toggle ? "R8" : "R7", "pulses missing", exp_q.size(), 0);
      end
    end
    repeat (3) @(negedge clk);
    chk(state_o == 4'b1000, "R3", "idle holds with low input", state_o, 4'b1000);
  endtask

  initial begin
    #200_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(state_o == 4'b1000, "R1", "reset state", state_o, 4'b1000);
    chk(pulse_cnt_o == 0 && cnt_zero_o, "R1", "reset count", pulse_cnt_o, 0);
    chk(pulse_out == 1'b0, "R1", "reset output", pulse_out, 0);
    rst_por = 1'b0;
    @(negedge clk);
    chk(state_o == 4'b1000, "R1", "idle after release", state_o, 4'b1000);
    chk($countones(state_o) == 1, "R2", "one-hot", state_o, 1);
    burst(1, 1'b0);
    burst(4, 1'b0);
    burst(2, 1'b1);
    burst(9, 1'b0);
    burst(1, 1'b1);
    repeat (5) @(negedge clk);
    chk(pulse_out == 1'b0 && exp_q.size() == 0, "R8", "no stray burst", pulse_out, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule